// File: doc/BRIEF.md
# Space Vector PWM Sequencer

This block turns precomputed space-vector dwell counts into gate commands for a two-level, three-phase inverter. Each switching period is a fixed number of clock cycles, measured by a free-running counter. The period is split into eight segments that are mirrored about its midpoint: zero vector V0, the first active vector, the second active vector, zero vector V7, and then the same four in reverse order. A zero-vector segment lasts a quarter of the zero dwell. An active-vector segment lasts half of that vector's dwell. V7 takes whatever is left of each half-period.

The sector input picks which pair of adjacent non-zero vectors is used. The order of the pair alternates between odd and even sectors, so each step along the sequence changes only one phase. Dwell counts and the sector are captured only when a new period begins, so upstream logic can update them at any time. Each vector drives three upper gates from its phase bits, and each lower gate is the complement of its upper gate. The block also outputs the index of the vector being applied and a one-cycle strobe at every segment change.

Top module: `svpwm_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge restarts the period counter. After such an edge, `vec_idx_o` is 0, every upper gate is off, every lower gate is on, and `seg_strobe_o` is low. The same edge captures the dwell and sector inputs for the first period.
- R2: Vector index v maps to phase bits {A,B,C} as follows: 0→000, 1→100, 2→110, 3→010, 4→011, 5→001, 6→101, 7→111. `gate_up_o[2:0]` equals these bits, with A on bit 2 and C on bit 0. `gate_dn_o` is always the bitwise complement of `gate_up_o`.
- R3: Sector s (1 to 6) lies between vectors Vs and Vs+1, where V6 is followed by V1. In an odd sector the first active vector is Vs and the second is Vs+1. In an even sector the order is reversed. Sector codes 0 and 7 behave like sector 1.
- R4: Each period applies V0, first active, second active, V7, V7, second active, first active, V0. A segment of length zero is skipped.
- R5: Let H = PERIOD/2, q = floor(zero dwell/4), a = floor(first dwell/2) and b = floor(second dwell/2). In the first half, position x = counter value. In the second half, x = PERIOD−1−counter. The vector is V0 for x < q, first active for x < q+a, second active for x < q+a+b, and V7 otherwise.
- R6: The dwell and sector inputs are captured only in the cycle where the counter wraps from PERIOD−1 to 0 (and at reset). Changes at any other time have no effect until the next period.
- R7: If zero dwell + first dwell + second dwell exceeds PERIOD, q is forced to 0 for that period. Active segments that reach past the half-period boundary are cut off there.
- R8: `seg_strobe_o` is high for exactly those cycles in which the segment number differs from the one in the previous cycle. This includes the wrap into a new period and the mirror point at H. Outputs are registered, one cycle after the counter value that selects them.
- R9: The period counter runs freely with a length of PERIOD cycles.
- R10: When all three dwell quarters/halves are non-zero and the sector is held, consecutive applied vectors differ in at most one phase bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sector_i | input | 3 | Sector number, 1 to 6 |
| dwell_zero_i | input | DW | Total zero-vector dwell in cycles |
| dwell_a_i | input | DW | Dwell of the first active vector of the sector pair |
| dwell_b_i | input | DW | Dwell of the second active vector of the sector pair |
| vec_idx_o | output | 3 | Index of the vector being applied (0 to 7) |
| gate_up_o | output | 3 | Upper switch commands, bit 2 = phase A |
| gate_dn_o | output | 3 | Lower switch commands, complement of upper |
| seg_strobe_o | output | 1 | One-cycle pulse at each segment change |

## Verification
Every cycle, the assertions check the following:
- The lower gates are the complement of the upper gates.
- The upper gates match the phase encoding of the reported vector.
- The vector never changes without a strobe.
- The outputs are clean right after reset.

Only the bench scenarios can show the rest: the segment lengths, the sector-dependent vector order, saturation, the single-phase step property, and the fact that inputs changed mid-period are ignored until the boundary. The bench shows these by tracking a cycle-accurate expectation across several sectors and dwell patterns.

// File: rtl/svpwm_pkg.sv
// Shared types and vector helpers for the space vector sequencer.
package svpwm_pkg;

    typedef logic [2:0] vec_idx_t;   // vector number 0..7
    typedef logic [2:0] phase_t;     // {A,B,C}, 1 = upper switch on
    typedef logic [2:0] seg_t;       // segment number 0..7 within a period

    // Phase bits of each switching vector.
    function automatic phase_t vec_phase(input vec_idx_t v);
        phase_t p;
        case (v)
            3'd1:    p = 3'b100;
            3'd2:    p = 3'b110;
            3'd3:    p = 3'b010;
            3'd4:    p = 3'b011;
            3'd5:    p = 3'b001;
            3'd6:    p = 3'b101;
            3'd7:    p = 3'b111;
            default: p = 3'b000;
        endcase
        return p;
    endfunction

    // Next non-zero vector around the hexagon (V6 wraps to V1).
    function automatic vec_idx_t vec_next(input vec_idx_t v);
        return (v == 3'd6) ? 3'd1 : vec_idx_t'(v + 3'd1);
    endfunction

endpackage

// File: rtl/svpwm_timer.sv
// Period counter and dwell capture.
// Counts 0..PERIOD-1 freely. It captures the dwell and sector inputs on the
// wrap edge and on reset, and converts the dwells to segment lengths,
// forcing the zero quarter to 0 when the dwell sum overflows the period.
// Assumes PERIOD is even and at least 4.
module svpwm_timer #(
    parameter int PERIOD = 64,
    parameter int DW     = 8,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sector_i,
    input  logic [DW-1:0] t0_i,
    input  logic [DW-1:0] t1_i,
    input  logic [DW-1:0] t2_i,
    output logic [CW-1:0] cnt_o,
    output logic [DW-1:0] q_o,
    output logic [DW-1:0] h1_o,
    output logic [DW-1:0] h2_o,
    output logic [2:0]    sector_o
);
    localparam int SW = DW + 2;

    logic          wrap;
    logic [SW-1:0] dwell_sum;
    logic          overfull;

    // Detect the last cycle of the period.
    always_comb wrap = (cnt_o == CW'(PERIOD - 1));

    // Compare the total requested dwell with the period.
    always_comb begin
        dwell_sum = SW'(t0_i) + SW'(t1_i) + SW'(t2_i);
        overfull  = (dwell_sum > SW'(PERIOD));
    end

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_o <= '0;
        else if (wrap) cnt_o <= '0;
        else           cnt_o <= cnt_o + 1'b1;
    end

    // Capture segment lengths at reset and at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) begin
            q_o      <= overfull ? '0 : (t0_i >> 2);
            h1_o     <= t1_i >> 1;
            h2_o     <= t2_i >> 1;
            sector_o <= sector_i;
        end
    end

endmodule

// File: rtl/svpwm_segment.sv
// Segment classifier.
// Folds the counter about the period midpoint and compares the folded
// position with the cumulative segment edges to get the segment number and
// the vector it applies. Purely combinational.
// Assumes that the inputs come from svpwm_timer with the same parameters.
module svpwm_segment #(
    parameter int PERIOD = 64,
    parameter int DW     = 8,
    localparam int CW    = $clog2(PERIOD),
    localparam int EW    = ((DW + 2) > (CW + 1)) ? (DW + 2) : (CW + 1),
    localparam int HALF  = PERIOD / 2
) (
    input  logic [CW-1:0]       cnt_i,
    input  logic [DW-1:0]       q_i,
    input  logic [DW-1:0]       h1_i,
    input  logic [DW-1:0]       h2_i,
    input  logic [2:0]          sector_i,
    output svpwm_pkg::seg_t     seg_o,
    output svpwm_pkg::vec_idx_t vec_o
);
    import svpwm_pkg::*;

    logic          upper_half;
    logic [EW-1:0] pos;
    logic [EW-1:0] edge1, edge2, edge3;
    seg_t          half_seg;
    vec_idx_t      base, act_first, act_second;

    // Fold the counter into a position within the current half.
    always_comb begin
        upper_half = (EW'(cnt_i) >= EW'(HALF));
        pos        = upper_half ? (EW'(PERIOD - 1) - EW'(cnt_i)) : EW'(cnt_i);
    end

    // Cumulative segment edges and the segment number in the first half.
    always_comb begin
        edge1 = EW'(q_i);
        edge2 = edge1 + EW'(h1_i);
        edge3 = edge2 + EW'(h2_i);
        if (pos < edge1)      half_seg = 3'd0;
        else if (pos < edge2) half_seg = 3'd1;
        else if (pos < edge3) half_seg = 3'd2;
        else                  half_seg = 3'd3;
        seg_o = upper_half ? seg_t'(3'd7 - half_seg) : half_seg;
    end

    // Sector to ordered pair of active vectors.
    always_comb begin
        base = ((sector_i == 3'd0) || (sector_i == 3'd7)) ? 3'd1 : sector_i;
        if (base[0]) begin
            act_first  = base;
            act_second = vec_next(base);
        end else begin
            act_first  = vec_next(base);
            act_second = base;
        end
    end

    // Segment number to applied vector.
    always_comb begin
        case (seg_o)
            3'd1, 3'd6: vec_o = act_first;
            3'd2, 3'd5: vec_o = act_second;
            3'd3, 3'd4: vec_o = 3'd7;
            default:    vec_o = 3'd0;
        endcase
    end

endmodule

// File: rtl/svpwm_gate.sv
// Output stage.
// Registers the applied vector and raises a strobe when the segment number
// changes. It drives complementary upper and lower gates from the vector's
// phase bits. Reset leaves V0 applied with segment 0 as the last segment seen.
module svpwm_gate (
    input  logic                clk,
    input  logic                rst_n,
    input  svpwm_pkg::seg_t     seg_i,
    input  svpwm_pkg::vec_idx_t vec_i,
    output svpwm_pkg::vec_idx_t vec_o,
    output logic [2:0]          up_o,
    output logic [2:0]          dn_o,
    output logic                strobe_o
);
    import svpwm_pkg::*;

    seg_t seg_q;

    // Register the vector, the segment and the segment-change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_o    <= '0;
            seg_q    <= '0;
            strobe_o <= 1'b0;
        end else begin
            vec_o    <= vec_i;
            seg_q    <= seg_i;
            strobe_o <= (seg_i != seg_q);
        end
    end

    // Complementary gate commands from the registered vector.
    always_comb begin
        up_o = vec_phase(vec_o);
        dn_o = ~up_o;
    end

endmodule

// File: rtl/svpwm_seq.sv
// Space vector PWM sequencer top.
// Ties together the period timer, the segment classifier and the output
// stage. Outputs are one register after the counter value that selects
// them. Assumes PERIOD is even and that dwell counts are in clock cycles.
module svpwm_seq #(
    parameter int PERIOD = 64,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sector_i,
    input  logic [DW-1:0] dwell_zero_i,
    input  logic [DW-1:0] dwell_a_i,
    input  logic [DW-1:0] dwell_b_i,
    output logic [2:0]    vec_idx_o,
    output logic [2:0]    gate_up_o,
    output logic [2:0]    gate_dn_o,
    output logic          seg_strobe_o
);
    import svpwm_pkg::*;

    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt;
    logic [DW-1:0] q_len, h1_len, h2_len;
    logic [2:0]    sector_lat;
    seg_t          seg_now;
    vec_idx_t      vec_now;

    svpwm_timer #(.PERIOD(PERIOD), .DW(DW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sector_i (sector_i),
        .t0_i     (dwell_zero_i),
        .t1_i     (dwell_a_i),
        .t2_i     (dwell_b_i),
        .cnt_o    (cnt),
        .q_o      (q_len),
        .h1_o     (h1_len),
        .h2_o     (h2_len),
        .sector_o (sector_lat)
    );

    svpwm_segment #(.PERIOD(PERIOD), .DW(DW)) u_segment (
        .cnt_i    (cnt),
        .q_i      (q_len),
        .h1_i     (h1_len),
        .h2_i     (h2_len),
        .sector_i (sector_lat),
        .seg_o    (seg_now),
        .vec_o    (vec_now)
    );

    svpwm_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .seg_i    (seg_now),
        .vec_i    (vec_now),
        .vec_o    (vec_idx_o),
        .up_o     (gate_up_o),
        .dn_o     (gate_dn_o),
        .strobe_o (seg_strobe_o)
    );

endmodule

// File: rtl/svpwm_seq_chk.sv
// Port-level checker for svpwm_seq, attached by bind.
// Checks the gate encoding, complementarity, vector stability between
// strobes, and the state right after reset.
module svpwm_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] vec_idx_o,
    input logic [2:0] gate_up_o,
    input logic [2:0] gate_dn_o,
    input logic       seg_strobe_o
);
    logic rst_q;

    // Remember the reset level of the previous edge.
    always_ff @(posedge clk) rst_q <= rst_n;

    function automatic logic [2:0] phase_of(input logic [2:0] v);
        case (v)
            3'd1:    return 3'b100;
            3'd2:    return 3'b110;
            3'd3:    return 3'b010;
            3'd4:    return 3'b011;
            3'd5:    return 3'b001;
            3'd6:    return 3'b101;
            3'd7:    return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    // R2
    gate_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_dn_o == ~gate_up_o);

    // R2
    gate_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_up_o == phase_of(vec_idx_o));

    // R8
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && !seg_strobe_o) |-> $stable(vec_idx_o));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_q |-> (vec_idx_o == 3'd0 && gate_up_o == 3'b000 && !seg_strobe_o));

endmodule

bind svpwm_seq svpwm_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vec_idx_o    (vec_idx_o),
    .gate_up_o    (gate_up_o),
    .gate_dn_o    (gate_dn_o),
    .seg_strobe_o (seg_strobe_o)
);

// File: tb/test_svpwm_seq.sv
// Scoreboard bench: a driver predicts each edge's outputs into queues; a
// monitor pops and compares them on the falling edge.
module test_svpwm_seq;
    localparam int PERIOD = 64;
    localparam int DW     = 8;
    localparam int HALF   = PERIOD / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    sector;
    logic [DW-1:0] tz, ta, tb;
    logic [2:0]    vec_idx, gup, gdn;
    logic          stb;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    bit chk_single = 0;
    string cur_tag = "R1";

    // model state
    int m_cnt = 0, m_q = 0, m_a = 0, m_b = 0, m_sec = 1, m_prev_seg = 0;

    int    q_vec[$];
    int    q_stb[$];
    string q_tag[$];

    always #4 clk = ~clk;   // 125 MHz

    svpwm_seq #(.PERIOD(PERIOD), .DW(DW)) i_svpwm_seq (
        .clk(clk), .rst_n(rst_n), .sector_i(sector),
        .dwell_zero_i(tz), .dwell_a_i(ta), .dwell_b_i(tb),
        .vec_idx_o(vec_idx), .gate_up_o(gup), .gate_dn_o(gdn),
        .seg_strobe_o(stb)
    );

    function automatic logic [2:0] bits_of(input int v);
        case (v)
            1: return 3'b100;  2: return 3'b110;  3: return 3'b010;
            4: return 3'b011;  5: return 3'b001;  6: return 3'b101;
            7: return 3'b111;  default: return 3'b000;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected segment from the R5/R7 length rules.
    function automatic int exp_seg(input int c);
        int x, s;
        x = (c < HALF) ? c : (PERIOD - 1 - c);
        if (x < m_q) s = 0;
        else if (x < m_q + m_a) s = 1;
        else if (x < m_q + m_a + m_b) s = 2;
        else s = 3;
        return (c < HALF) ? s : 7 - s;
    endfunction

    // Expected vector for a segment from the R3 pair rules.
    function automatic int exp_vec(input int s);
        int base, f, g;
        base = (m_sec < 1 || m_sec > 6) ? 1 : m_sec;
        if (base % 2 == 1) begin f = base; g = (base == 6) ? 1 : base + 1; end
        else begin f = (base == 6) ? 1 : base + 1; g = base; end
        case (s)
            1, 6:    return f;
            2, 5:    return g;
            3, 4:    return 7;
            default: return 0;
        endcase
    endfunction

    function automatic void capture();
        m_q   = ((int'(tz) + int'(ta) + int'(tb)) > PERIOD) ? 0 : int'(tz) / 4;
        m_a   = int'(ta) / 2;
        m_b   = int'(tb) / 2;
        m_sec = int'(sector);
    endfunction

    // Driver: predict the outputs after the coming edge, then pass the edge.
    task automatic tick();
        int s;
        if (!rst_n) begin
            m_cnt = 0; m_prev_seg = 0; capture();
            q_vec.push_back(0); q_stb.push_back(0);
        end else begin
            s = exp_seg(m_cnt);
            q_vec.push_back(exp_vec(s));
            q_stb.push_back(s != m_prev_seg);
            m_prev_seg = s;
            if (m_cnt == PERIOD - 1) begin m_cnt = 0; capture(); end
            else m_cnt++;
        end
        q_tag.push_back(cur_tag);
        @(posedge clk);
        #2;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic setd(input int s, input int z, input int a, input int b);
        sector = 3'(s); tz = DW'(z); ta = DW'(a); tb = DW'(b);
    endtask

    // Monitor: pop and compare every cycle.
    logic [2:0] prev_vec = 3'd0;
    always @(negedge clk) begin
        if (q_vec.size() > 0) begin
            int ev, es;
            string tg;
            ev = q_vec.pop_front(); es = q_stb.pop_front(); tg = q_tag.pop_front();
            check(vec_idx == 3'(ev), {tg, " vector"}, vec_idx, ev);
            check(stb == es[0], "R8 strobe", stb, es);
            check(gup == bits_of(int'(vec_idx)), "R2 upper gates", gup, bits_of(int'(vec_idx)));
            check(gdn == ~gup, "R2 lower gates", gdn, ~gup);
            if (chk_single && vec_idx != prev_vec)
                check($countones(bits_of(int'(vec_idx)) ^ bits_of(int'(prev_vec))) <= 1,
                      "R10 single phase step", vec_idx, prev_vec);
            prev_vec = vec_idx;
        end
    end

    initial begin
        rst_n = 1'b0;
        setd(1, 24, 20, 20);
        cur_tag = "R1";
        run(3);
        rst_n = 1'b1;
        // R1 directed: state right after reset
        check(vec_idx == 3'd0 && gup == 3'b000 && gdn == 3'b111 && !stb,
              "R1 reset outputs", {vec_idx, gup}, 0);
        cur_tag = "R4 R5 R9 order and lengths";
        chk_single = 1;
        run(2 * PERIOD);
        for (int s = 2; s <= 6; s++) begin
            setd(s, 16 + 4 * s, 22 - 2 * s, 10 + s);
            cur_tag = "R3 sector pair";
            run(PERIOD);
        end
        chk_single = 0;
        setd(0, 24, 20, 20); cur_tag = "R3 sector code 0"; run(PERIOD);
        setd(7, 24, 12, 8);  cur_tag = "R3 sector code 7"; run(PERIOD);
        setd(3, 7, 9, 13);   cur_tag = "R5 odd dwell rounding"; run(PERIOD);
        cur_tag = "R6 mid-period change ignored";
        setd(4, 20, 30, 14); run(PERIOD / 2);
        setd(1, 60, 2, 2);   run(PERIOD / 2);
        run(PERIOD);
        setd(2, 40, 20, 20); cur_tag = "R7 saturation"; run(PERIOD);
        setd(5, 0, 60, 60);  cur_tag = "R7 clipped actives"; run(PERIOD);
        setd(6, 64, 0, 0);   cur_tag = "R9 zero only"; run(2 * PERIOD);
        setd(1, 24, 20, 20); cur_tag = "R1 mid-run reset";
        run(10);
        rst_n = 1'b0; run(2); rst_n = 1'b1;
        check(vec_idx == 3'd0 && !stb, "R1 reset outputs mid-run", vec_idx, 0);
        cur_tag = "R9 after reset"; run(PERIOD);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule